// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block lives inside a memory controller and turns CPU stores into the commands an SDRAM needs at power-up. Two address windows are reserved, one for each SDRAM chip-select region. A byte store into a window does not move any data. It issues one command on the SDRAM command pins, and a control input selects which command that is. With the control input low, the store issues precharge-all to the addressed region. With it high, the store issues mode-register-set, and the store's offset inside the window, shifted right by two, is driven as the mode word on the SDRAM address pins.

The sequencer also enforces the power-up rules:
- It rejects window stores until an idle time has passed after reset. That time is given in microseconds and converted to cycles through a clock-frequency parameter.
- After each precharge-all it issues auto-refresh commands to both regions. These are paced by a programmable compare value.
- It refuses mode-register-set until a minimum number of those refreshes has gone out.

A rejected request issues no command and sets a sticky error flag. Once a mode-register-set has been accepted, the done flag rises. Refreshes continue after that point.

Top module: `sdram_init_seq`

## Requirements
- R1: After a synchronous reset, all command pins are high (no-operation), `sd_addr` is zero, and `init_done` and `seq_err` are low.
- R2: For the first `IDLE_US*CLK_MHZ` cycles after reset, a window store issues no command and sets `seq_err`.
- R3: A window store is a `bus_wr` with `bus_byte` high and `bus_addr[31:19]` equal to `0x1FF2`. The bases are 0xFF900000 and 0xFF940000, and `bus_addr[18]` selects the region: 0 drives `sd_cs_n` to `2'b10`, 1 drives it to `2'b01`. Stores to other addresses, and stores that are not byte-size, issue nothing and leave `seq_err` unchanged.
- R4: An accepted store with `mrs_sel` low issues precharge-all on the cycle after the store. The encoding is: the region's chip select low, `ras` low, `cas` high, `we` low, `sd_addr` = 0x400 (line 10 high). It also clears `init_done`.
- R5: After a precharge-all, auto-refresh commands go out every `ref_interval+1` cycles. The encoding is: both chip selects low, `ras` and `cas` low, `we` high.
- R6: A store with `mrs_sel` high that arrives before `REF_MIN` refreshes have been issued since the latest precharge-all issues no command and sets `seq_err`.
- R7: An accepted mode-register-set drives all four command pins low on the region's chip select, with `sd_addr` = `bus_addr[14:2]`. Offset 0x48 gives 0x012 (CAS latency 1, burst 4), and offset 0xCC gives 0x033 (CAS latency 3, burst 8).
- R8: Only certain mode words are accepted:
  - burst field `[2:1]` = 01 (burst 4 or 8), wrap bit `[3]` = 0;
  - latency field `[6:4]` set to 1, 2 or 3, and `[12:7]` zero;
  - `bus_addr[1:0]` and `bus_addr[17:15]` zero.

  Any other word issues no command and sets `seq_err`.
- R9: `init_done` rises together with an accepted mode-register-set on the pins. It stays high until the next precharge-all.
- R10: When a window command and a due refresh fall in the same cycle, the window command is issued first. The refresh follows on the next cycle and is not lost.
- R11: `seq_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | CPU store strobe |
| bus_addr | input | 32 | CPU store address |
| bus_byte | input | 1 | Store is byte-size |
| mrs_sel | input | 1 | 0: precharge-all, 1: mode-register-set |
| ref_interval | input | CMP_W | Refresh compare value (interval minus one) |
| sd_cs_n | output | 2 | Chip selects, bit 0 region A, bit 1 region B |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | SD_ADDR_W | SDRAM address lines |
| init_done | output | 1 | Mode programmed |
| seq_err | output | 1 | Sticky sequence error |

## Verification
A window command and a refresh request can fall in the same cycle, and only one of them can occupy the command pins. To provoke this, the compare value is set to 1 so that refreshes appear every second cycle. The bench watches for a refresh on the pins and times the mode-register-set store so that it is sampled exactly when the next refresh is due. It then judges that the mode command appears first and that a refresh occupies the very next cycle.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE_WAIT,
    ST_READY_PALL,
    ST_REFRESHING,
    ST_READY_MRS,
    ST_DONE
  } sdi_state_t;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PALL,
    CMD_REF,
    CMD_MRS
  } sdi_cmd_t;
endpackage

// File: rtl/sdi_idle_timer.sv
module sdi_idle_timer #(
  parameter int CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(CYCLES - 1)) done <= 1'b1;
    end
  end
endmodule

// File: rtl/sdi_refresh_timer.sv
module sdi_refresh_timer #(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CMP_W-1:0] cmp,
  input  logic             ack,
  output logic             req
);
  logic [CMP_W-1:0] cnt;
  logic             tick;

  assign tick = en && (cnt >= cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      req <= 1'b0;
    end else begin
      if (!en || tick) cnt <= '0;
      else             cnt <= cnt + 1'b1;
      // a pending request survives a cycle without acknowledge
      req <= en && (tick || (req && !ack));
    end
  end
endmodule

// File: rtl/sdi_win_decode.sv
module sdi_win_decode #(
  parameter logic [31:0] WIN_BASE  = 32'hFF90_0000,
  parameter int          SD_ADDR_W = 13
) (
  input  logic [31:0]          addr,
  output logic                 hit,
  output logic                 region,
  output logic [SD_ADDR_W-1:0] mode,
  output logic                 legal
);
  localparam int REG_BIT = 18;
  localparam int TOP_M   = SD_ADDR_W + 2;

  assign hit    = (addr[31:REG_BIT+1] == WIN_BASE[31:REG_BIT+1]);
  assign region = addr[REG_BIT];
  assign mode   = addr[TOP_M-1:2];

  always_comb begin
    legal = (addr[1:0] == 2'b00)
         && (addr[REG_BIT-1:TOP_M] == '0)
         && (mode[2:1] == 2'b01)
         && !mode[3]
         && !mode[6]
         && (mode[5:4] != 2'b00)
         && (mode[SD_ADDR_W-1:7] == '0);
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdi_pkg::*;
#(
  parameter int          CLK_MHZ   = 100,
  parameter int          IDLE_US   = 200,
  parameter int          REF_MIN   = 8,
  parameter int          CMP_W     = 16,
  parameter int          SD_ADDR_W = 13,
  parameter logic [31:0] WIN_BASE  = 32'hFF90_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_addr,
  input  logic                 bus_byte,
  input  logic                 mrs_sel,
  input  logic [CMP_W-1:0]     ref_interval,
  output logic [1:0]           sd_cs_n,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [SD_ADDR_W-1:0] sd_addr,
  output logic                 init_done,
  output logic                 seq_err
);
  localparam int IDLE_CYC = IDLE_US * CLK_MHZ;
  localparam int RC_W     = $clog2(REF_MIN + 1);

  sdi_state_t           state, state_n;
  sdi_cmd_t             cmd;
  logic [RC_W-1:0]      ref_cnt, ref_cnt_n;
  logic                 err_n, done_n;
  logic                 idle_done, ref_req, ref_en;
  logic                 hit, region, legal, win;
  logic [SD_ADDR_W-1:0] mode;

  sdi_idle_timer #(.CYCLES(IDLE_CYC)) u_idle (
    .clk(clk), .rst(rst), .done(idle_done)
  );

  sdi_win_decode #(.WIN_BASE(WIN_BASE), .SD_ADDR_W(SD_ADDR_W)) u_dec (
    .addr(bus_addr), .hit(hit), .region(region), .mode(mode), .legal(legal)
  );

  assign ref_en = (state == ST_REFRESHING) || (state == ST_READY_MRS) || (state == ST_DONE);

  sdi_refresh_timer #(.CMP_W(CMP_W)) u_ref (
    .clk(clk), .rst(rst), .en(ref_en), .cmp(ref_interval),
    .ack(cmd == CMD_REF), .req(ref_req)
  );

  assign win = bus_wr && bus_byte && hit;

  always_comb begin
    cmd       = CMD_NOP;
    state_n   = state;
    ref_cnt_n = ref_cnt;
    err_n     = seq_err;
    done_n    = init_done;
    if (state == ST_IDLE_WAIT && idle_done) state_n = ST_READY_PALL;
    if (win) begin
      if (state == ST_IDLE_WAIT) begin
        err_n = 1'b1;
      end else if (!mrs_sel) begin
        cmd       = CMD_PALL;
        state_n   = ST_REFRESHING;
        ref_cnt_n = '0;
        done_n    = 1'b0;
      end else if ((state == ST_READY_MRS || state == ST_DONE) && legal) begin
        cmd     = CMD_MRS;
        state_n = ST_DONE;
        done_n  = 1'b1;
      end else begin
        err_n = 1'b1;
      end
    end
    // refresh takes the pins only when no window command owns them
    if (cmd == CMD_NOP && ref_req) begin
      cmd = CMD_REF;
      if (ref_cnt < RC_W'(REF_MIN)) ref_cnt_n = ref_cnt + 1'b1;
      if (state == ST_REFRESHING && ref_cnt == RC_W'(REF_MIN - 1)) state_n = ST_READY_MRS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE_WAIT;
      ref_cnt   <= '0;
      seq_err   <= 1'b0;
      init_done <= 1'b0;
      sd_cs_n   <= 2'b11;
      sd_ras_n  <= 1'b1;
      sd_cas_n  <= 1'b1;
      sd_we_n   <= 1'b1;
      sd_addr   <= '0;
    end else begin
      state     <= state_n;
      ref_cnt   <= ref_cnt_n;
      seq_err   <= err_n;
      init_done <= done_n;
      case (cmd)
        CMD_PALL: begin
          sd_cs_n  <= region ? 2'b01 : 2'b10;
          sd_ras_n <= 1'b0;
          sd_cas_n <= 1'b1;
          sd_we_n  <= 1'b0;
          sd_addr  <= SD_ADDR_W'(1) << 10;
        end
        CMD_REF: begin
          sd_cs_n  <= 2'b00;
          sd_ras_n <= 1'b0;
          sd_cas_n <= 1'b0;
          sd_we_n  <= 1'b1;
          sd_addr  <= '0;
        end
        CMD_MRS: begin
          sd_cs_n  <= region ? 2'b01 : 2'b10;
          sd_ras_n <= 1'b0;
          sd_cas_n <= 1'b0;
          sd_we_n  <= 1'b0;
          sd_addr  <= mode;
        end
        default: begin
          sd_cs_n  <= 2'b11;
          sd_ras_n <= 1'b1;
          sd_cas_n <= 1'b1;
          sd_we_n  <= 1'b1;
          sd_addr  <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int IDLE_CYC  = 20000,
  parameter int REF_MIN   = 8,
  parameter int SD_ADDR_W = 13
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           sd_cs_n,
  input logic                 sd_ras_n,
  input logic                 sd_cas_n,
  input logic                 sd_we_n,
  input logic [SD_ADDR_W-1:0] sd_addr,
  input logic                 init_done,
  input logic                 seq_err
);
  localparam int UW = $clog2(IDLE_CYC + 1);
  localparam int RW = $clog2(REF_MIN + 1);

  logic          pall_p, mrs_p, ref_p;
  logic [UW-1:0] up;
  logic [RW-1:0] refs;

  assign pall_p = (^sd_cs_n) && !sd_ras_n && sd_cas_n && !sd_we_n;
  assign mrs_p  = (^sd_cs_n) && !sd_ras_n && !sd_cas_n && !sd_we_n;
  assign ref_p  = (sd_cs_n == 2'b00) && !sd_ras_n && !sd_cas_n && sd_we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      up   <= '0;
      refs <= '0;
    end else begin
      if (up < UW'(IDLE_CYC)) up <= up + 1'b1;
      if (pall_p) refs <= '0;
      else if (ref_p && refs < RW'(REF_MIN)) refs <= refs + 1'b1;
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (pall_p || mrs_p) |-> (up >= UW'(IDLE_CYC)));

  assert_pall_line10_R4: assert property (@(posedge clk) disable iff (rst)
    pall_p |-> sd_addr[10]);

  assert_mrs_after_refresh_R6: assert property (@(posedge clk) disable iff (rst)
    mrs_p |-> (refs >= RW'(REF_MIN)));

  assert_mrs_mode_legal_R8: assert property (@(posedge clk) disable iff (rst)
    mrs_p |-> (sd_addr[2:1] == 2'b01 && !sd_addr[3] && !sd_addr[6]
               && sd_addr[5:4] != 2'b00 && sd_addr[SD_ADDR_W-1:7] == '0));

  assert_done_with_mrs_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> mrs_p);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(seq_err)) |-> seq_err);
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .IDLE_CYC(IDLE_CYC), .REF_MIN(REF_MIN), .SD_ADDR_W(SD_ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
  .init_done(init_done), .seq_err(seq_err)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;
  localparam int IDLE = 30;

  typedef struct {
    logic [1:0]  cs;
    logic [2:0]  rcw;
    logic [12:0] addr;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_byte = 1'b0;
  logic        mrs_sel = 1'b0;
  logic [15:0] ref_interval = 16'd1;
  logic [1:0]  sd_cs_n;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [12:0] sd_addr;
  logic        init_done, seq_err;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  sdram_init_seq #(.CLK_MHZ(10), .IDLE_US(3)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_byte(bus_byte), .mrs_sel(mrs_sel), .ref_interval(ref_interval),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_addr(sd_addr), .init_done(init_done),
    .seq_err(seq_err)
  );

  function automatic logic is_ref();
    return sd_cs_n == 2'b00 && !sd_ras_n && !sd_cas_n && sd_we_n;
  endfunction

  function automatic logic is_mrs();
    return sd_cs_n != 2'b11 && !sd_ras_n && !sd_cas_n && !sd_we_n;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] cs, input logic [2:0] rcw,
                      input logic [12:0] a, input string tag);
    exp_t e;
    e.cs = cs; e.rcw = rcw; e.addr = a; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: every non-refresh command must match the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && sd_cs_n != 2'b11 && !is_ref()) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 unexpected command", {19'd0, sd_addr}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(sd_cs_n == e.cs && {sd_ras_n, sd_cas_n, sd_we_n} == e.rcw
              && sd_addr == e.addr, e.tag,
              {14'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr},
              {14'd0, e.cs, e.rcw, e.addr});
      end
    end
  end

  task automatic win_wr(input logic [31:0] a, input logic sel, input logic byt);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; mrs_sel = sel; bus_byte = byt;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_ref(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!is_ref());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(sd_cs_n == 2'b11 && sd_ras_n && sd_cas_n && sd_we_n && sd_addr == 0,
          "R1 pins idle", {16'd0, sd_cs_n, sd_addr}, {16'd0, 2'b11, 13'd0});
    check(!init_done && !seq_err, "R1 flags", {init_done, seq_err}, 0);

    // R3 stores outside the window or not byte-size are ignored
    win_wr(32'h1234_0048, 1'b0, 1'b1);
    check(sd_cs_n == 2'b11 && !seq_err, "R3 foreign address", {sd_cs_n, seq_err}, 32'b110);
    win_wr(32'hFF90_0048, 1'b0, 1'b0);
    check(sd_cs_n == 2'b11 && !seq_err, "R3 non-byte store", {sd_cs_n, seq_err}, 32'b110);

    // R2 store during idle time rejected
    win_wr(32'hFF90_0000, 1'b0, 1'b1);
    check(sd_cs_n == 2'b11 && seq_err, "R2 early store", {sd_cs_n, seq_err}, 32'b111);
    repeat (10) @(negedge clk);
    check(seq_err, "R11 error held", seq_err, 1);

    do_reset();
    repeat (IDLE + 10) @(negedge clk);

    // R4 precharge-all, region B
    push(2'b01, 3'b010, 13'h400, "R4 precharge-all");
    win_wr(32'hFF94_0123, 1'b0, 1'b1);
    check(sd_cs_n == 2'b01 && sd_addr[10], "R4 region B pins", {sd_cs_n, sd_addr}, {2'b01, 13'h400});

    // R5 refresh pacing: interval 1 gives one refresh every 2 cycles
    wait_ref(g);
    wait_ref(g);
    check(g == 2, "R5 refresh spacing", g, 2);
    for (int i = 0; i < 6; i++) wait_ref(g);
    check(!init_done && !seq_err, "R9 not done yet", {init_done, seq_err}, 0);

    // R10 collision: store sampled exactly when the next refresh is due
    push(2'b10, 3'b000, 13'h012, "R7 mode 0x48");
    win_wr(32'hFF90_0048, 1'b1, 1'b1);
    check(is_mrs() && sd_addr == 13'h012, "R10 window command first", sd_addr, 13'h012);
    check(init_done, "R9 done with mode set", init_done, 1);
    @(negedge clk);
    check(is_ref(), "R10 deferred refresh next cycle",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'b00001);

    // R7 region B, latency 3 burst 8
    push(2'b01, 3'b000, 13'h033, "R7 mode 0xCC");
    win_wr(32'hFF94_00CC, 1'b1, 1'b1);
    check(sd_addr == 13'h033 && sd_cs_n == 2'b01, "R7 mode word 0xCC", sd_addr, 13'h033);

    // R8 illegal burst field
    win_wr(32'hFF90_0040, 1'b1, 1'b1);
    check(!is_mrs() && seq_err, "R8 illegal mode rejected", {is_mrs(), seq_err}, 32'b01);

    // R9 precharge-all clears done
    push(2'b10, 3'b010, 13'h400, "R4 precharge-all region A");
    win_wr(32'hFF90_0000, 1'b0, 1'b1);
    check(!init_done, "R9 done cleared", init_done, 0);
    check(seq_err, "R11 error still held", seq_err, 1);

    // R6 mode set too early after precharge-all
    do_reset();
    repeat (IDLE + 10) @(negedge clk);
    check(!seq_err, "R11 reset clears error", seq_err, 0);
    push(2'b10, 3'b010, 13'h400, "R4 precharge-all again");
    win_wr(32'hFF90_0000, 1'b0, 1'b1);
    win_wr(32'hFF90_0088, 1'b1, 1'b1);
    check(!is_mrs() && seq_err && !init_done, "R6 early mode set rejected",
          {is_mrs(), seq_err, init_done}, 32'b010);

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule